// File: doc/BRIEF.md
# DMA End-of-Block Interrupt Controller

This block sits beside a serial bus peripheral and manages its receive and transmit DMA channels. Each channel has a DMA enable bit, a transfer counter and an end-of-block flag. Software loads a transfer count and sets the enable. Each transfer strobe from the DMA engine then counts the channel down by one. When the count reaches zero, the block sets the end-of-block flag and turns the channel's enable off on the same clock edge.

Software reaches the block through one 8-bit control byte and two count-load strobes. The control byte holds the two enables, the two end-of-block flags and three interrupt masks. Data-received, ready-to-transmit and error events arrive as single-cycle strobes. Each one is held pending until software acknowledges it on a separate acknowledge input. The block merges the pending events and the end-of-block flags, each gated by its mask, into one interrupt request.

Top module: `dma_eob_irq_ctrl`

## Requirements
- R1: After reset the control byte reads 0x00, both counters are 0, both enables are 0 and `irq` is 0.
- R2: Writing the control byte stores the enables (bit 7 receive, bit 6 transmit) and the masks (bit 2 error, bit 1 receive, bit 0 transmit). Bit 3 always reads 0, whatever is written to it.
- R3: The end-of-block flags (bit 5 receive, bit 4 transmit) are cleared by writing 0 to them. Writing 1 leaves them unchanged.
- R4: A transfer strobe lowers its channel's counter by one only while that channel's enable is 1 and its counter is nonzero. Otherwise the counter holds.
- R5: The strobe that takes a counter from 1 to 0 sets that channel's end-of-block flag and clears its enable on the same edge. Loading a count, including a count of 0, never sets the flag.
- R6: If the hardware sets an end-of-block flag in the same cycle that software writes 0 to it, the flag ends up set.
- R7: The interrupt masks have no effect on counting. A channel counts down under every mask value as long as its enable is 1.
- R8: `irq` is 1 exactly when at least one of these holds: the error pending bit and the error mask are both set; the receive mask is set and either the received-data pending bit or the receive end-of-block flag is set; the transmit mask is set and either the ready-to-transmit pending bit or the transmit end-of-block flag is set.
- R9: A pending event stays pending until its acknowledge bit is pulsed (bit 2 error, bit 1 receive, bit 0 transmit). If an event and its acknowledge arrive in the same cycle, the event remains pending.
- R10: If a count load and a transfer strobe arrive in the same cycle, the loaded value is kept and no end-of-block flag is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for the control byte |
| reg_wdata | input | 8 | Data written to the control byte |
| reg_rdata | output | 8 | Current control byte |
| rx_cnt_ld | input | 1 | Load strobe for the receive transfer count |
| tx_cnt_ld | input | 1 | Load strobe for the transmit transfer count |
| cnt_ld_data | input | CNT_W | Count value to load |
| rx_dma_stb | input | 1 | Receive DMA transfer done |
| tx_dma_stb | input | 1 | Transmit DMA transfer done |
| err_evt | input | 1 | Error condition strobe |
| rx_evt | input | 1 | Data-received strobe |
| tx_evt | input | 1 | Ready-to-transmit strobe |
| evt_ack | input | 3 | Acknowledges pending events: bit 2 error, bit 1 receive, bit 0 transmit |
| rx_cnt | output | CNT_W | Receive transfer counter |
| tx_cnt | output | CNT_W | Transmit transfer counter |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench loads every count from 0 to 6 on each channel and steps it down strobe by strobe. A design that decremented past zero or ignored the enable would show a wrapped or moving counter. One that raised the flag at the wrong step, or on a plain load, would show the flag early or late. Every mask value is swept against every combination of the five interrupt sources. This catches any source routed to the wrong mask, or a mask that also stalled counting. Three same-cycle collisions are forced: a flag set against a software clear, an event against its acknowledge, and a load against a strobe. A design with the wrong priority would lose the flag or the event, or would corrupt the loaded count.

// File: rtl/dma_eob_irq_pkg.sv
package dma_eob_irq_pkg;

  localparam int CH_TX = 0;
  localparam int CH_RX = 1;
  localparam int EN_BASE  = 6;
  localparam int EOB_BASE = 4;
  localparam int RSVD_BIT = 3;
  localparam int NUM_EVT  = 3;

  function automatic logic cnt_dec_ok(input logic stb, input logic en,
                                      input logic [31:0] cnt);
    return stb && en && (cnt != 32'd0);
  endfunction

  function automatic logic irq_merge(input logic [2:0] pend,
                                     input logic [1:0] eob,
                                     input logic [2:0] mask);
    logic any;
    any = |(pend & mask);
    any = any | (eob[CH_RX] & mask[CH_RX]) | (eob[CH_TX] & mask[CH_TX]);
    return any;
  endfunction

endpackage

// File: rtl/dma_eob_chan.sv
module dma_eob_chan
  import dma_eob_irq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  input  logic             stb,
  input  logic             en_wr,
  input  logic             en_wval,
  input  logic             eob_clr,
  output logic [CNT_W-1:0] cnt,
  output logic             en,
  output logic             eob,
  output logic             hit
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic dec;

  always_comb begin
    dec = cnt_dec_ok(stb, en, 32'(cnt));
    hit = dec && !ld && (cnt == ONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (ld) begin
      cnt <= ld_val;
    end else if (dec) begin
      cnt <= cnt - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= 1'b0;
    end else if (hit) begin
      en <= 1'b0;
    end else if (en_wr) begin
      en <= en_wval;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eob <= 1'b0;
    end else if (hit) begin
      eob <= 1'b1;
    end else if (eob_clr) begin
      eob <= 1'b0;
    end
  end

endmodule

// File: rtl/dma_evt_pend.sv
module dma_evt_pend #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic [N-1:0] ack,
  output logic [N-1:0] pend
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend[i] <= 1'b0;
      end else if (evt[i]) begin
        pend[i] <= 1'b1;
      end else if (ack[i]) begin
        pend[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dma_eob_irq_ctrl.sv
module dma_eob_irq_ctrl
  import dma_eob_irq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic             rx_cnt_ld,
  input  logic             tx_cnt_ld,
  input  logic [CNT_W-1:0] cnt_ld_data,
  input  logic             rx_dma_stb,
  input  logic             tx_dma_stb,
  input  logic             err_evt,
  input  logic             rx_evt,
  input  logic             tx_evt,
  input  logic [2:0]       evt_ack,
  output logic [CNT_W-1:0] rx_cnt,
  output logic [CNT_W-1:0] tx_cnt,
  output logic             irq
);
  logic [1:0]       ch_ld, ch_stb, ch_en, ch_eob, ch_hit;
  logic [CNT_W-1:0] ch_cnt [2];
  logic [2:0]       mask_q;
  logic [NUM_EVT-1:0] pend;

  logic rx_hit, tx_hit, err_pend;

  assign ch_ld  = {rx_cnt_ld, tx_cnt_ld};
  assign ch_stb = {rx_dma_stb, tx_dma_stb};

  for (genvar c = 0; c < 2; c++) begin : g_ch
    dma_eob_chan #(.CNT_W(CNT_W)) u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .ld      (ch_ld[c]),
      .ld_val  (cnt_ld_data),
      .stb     (ch_stb[c]),
      .en_wr   (reg_wr),
      .en_wval (reg_wdata[EN_BASE+c]),
      .eob_clr (reg_wr && !reg_wdata[EOB_BASE+c]),
      .cnt     (ch_cnt[c]),
      .en      (ch_en[c]),
      .eob     (ch_eob[c]),
      .hit     (ch_hit[c])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (reg_wr) begin
      mask_q <= reg_wdata[2:0];
    end
  end

  dma_evt_pend #(.N(NUM_EVT)) u_pend (
    .clk   (clk),
    .rst_n (rst_n),
    .evt   ({err_evt, rx_evt, tx_evt}),
    .ack   (evt_ack),
    .pend  (pend)
  );

  assign rx_hit   = ch_hit[CH_RX];
  assign tx_hit   = ch_hit[CH_TX];
  assign err_pend = pend[2];

  assign rx_cnt    = ch_cnt[CH_RX];
  assign tx_cnt    = ch_cnt[CH_TX];
  assign reg_rdata = {ch_en[CH_RX], ch_en[CH_TX], ch_eob[CH_RX], ch_eob[CH_TX],
                      1'b0, mask_q};
  assign irq       = irq_merge(pend, ch_eob, mask_q);

endmodule

// File: rtl/dma_eob_irq_chk.sv
module dma_eob_irq_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic [7:0]       reg_wdata,
  input logic [7:0]       reg_rdata,
  input logic             rx_cnt_ld,
  input logic [CNT_W-1:0] rx_cnt,
  input logic             irq,
  input logic             rx_hit,
  input logic             tx_hit,
  input logic             err_pend,
  input logic [2:0]       evt_ack
);
  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[3] == 1'b0);

  p_hold_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_rdata[7] && !rx_cnt_ld) |=> (rx_cnt == $past(rx_cnt)));

  p_rx_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_hit |=> (reg_rdata[5] && !reg_rdata[7] && rx_cnt == '0));

  p_tx_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_hit |=> (reg_rdata[4] && !reg_rdata[6]));

  p_eob_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[5] && !(reg_wr && !reg_wdata[5])) |=> reg_rdata[5]);

  p_irq_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[2:0] == 3'b000) |-> !irq);

  p_pend_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (err_pend && !evt_ack[2]) |=> err_pend);
endmodule

bind dma_eob_irq_ctrl dma_eob_irq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .rx_cnt_ld (rx_cnt_ld),
  .rx_cnt    (rx_cnt),
  .irq       (irq),
  .rx_hit    (rx_hit),
  .tx_hit    (tx_hit),
  .err_pend  (err_pend),
  .evt_ack   (evt_ack)
);

// File: tb/dma_eob_irq_ctrl_bench.sv
`timescale 1ns/1ps
module dma_eob_irq_ctrl_bench;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic rx_cnt_ld = 1'b0, tx_cnt_ld = 1'b0;
  logic [CNT_W-1:0] cnt_ld_data = '0;
  logic rx_dma_stb = 1'b0, tx_dma_stb = 1'b0;
  logic err_evt = 1'b0, rx_evt = 1'b0, tx_evt = 1'b0;
  logic [2:0] evt_ack = '0;
  logic [CNT_W-1:0] rx_cnt, tx_cnt;
  logic irq;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  dma_eob_irq_ctrl #(.CNT_W(CNT_W)) u_dma_eob_irq_ctrl (.*);

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic load(input bit ch_rx, input int v);
    @(negedge clk); cnt_ld_data = CNT_W'(v);
    rx_cnt_ld = ch_rx; tx_cnt_ld = !ch_rx;
    @(negedge clk); rx_cnt_ld = 1'b0; tx_cnt_ld = 1'b0;
  endtask

  task automatic strobe(input logic [1:0] which);
    @(negedge clk); rx_dma_stb = which[1]; tx_dma_stb = which[0];
    @(negedge clk); rx_dma_stb = 1'b0; tx_dma_stb = 1'b0;
  endtask

  task automatic pulse_evt(input logic [2:0] e, input logic [2:0] a);
    @(negedge clk); {err_evt, rx_evt, tx_evt} = e; evt_ack = a;
    @(negedge clk); {err_evt, rx_evt, tx_evt} = '0; evt_ack = '0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 rdata", int'(reg_rdata), 0);
    check("R1 irq", int'(irq), 0);
    check("R1 counts", int'(rx_cnt) + int'(tx_cnt), 0);

    // R2 readback, reserved bit stays 0
    wr(8'b1100_1111);
    check("R2 rdata", int'(reg_rdata), 8'b1100_0111);
    wr(8'b0000_1010);
    check("R2 rdata b", int'(reg_rdata), 8'b0000_0010);

    // R4 R5 R7 count-down sweep on both channels, all mask values
    for (int ch = 0; ch < 2; ch++) begin
      for (int L = 0; L <= 6; L++) begin
        logic [2:0] m;
        logic [7:0] en_bit;
        m = 3'(L + ch);
        en_bit = (ch == 1) ? 8'h80 : 8'h40;
        wr({5'b00000, m});
        load(ch == 1, L);
        check("R5 no eob on load", int'(reg_rdata[5:4]), 0);
        wr(en_bit | {5'b00000, m});
        for (int k = 1; k <= L + 2; k++) begin
          int exp_cnt;
          strobe(ch == 1 ? 2'b10 : 2'b01);
          exp_cnt = (L - k > 0) ? L - k : 0;
          check("R4 R7 count", int'(ch == 1 ? rx_cnt : tx_cnt), exp_cnt);
          check("R5 eob", int'(reg_rdata[4+ch]), (L > 0 && k >= L) ? 1 : 0);
          check("R5 enable", int'(reg_rdata[6+ch]), (L > 0 && k >= L) ? 0 : 1);
        end
        // R4 disabled channel holds
        wr(8'h00);
        load(ch == 1, 3);
        strobe(2'b11);
        check("R4 disabled hold", int'(ch == 1 ? rx_cnt : tx_cnt), 3);
      end
    end

    // R3 write-one keeps, write-zero clears
    load(1'b1, 1); wr(8'h80); strobe(2'b10);
    check("R3 set", int'(reg_rdata[5]), 1);
    wr(8'b0011_0000);
    check("R3 write1 keeps", int'(reg_rdata[5]), 1);
    wr(8'b0000_0000);
    check("R3 write0 clears", int'(reg_rdata[5]), 0);

    // R6 hardware set wins over software clear
    load(1'b0, 1); wr(8'h40);
    @(negedge clk); tx_dma_stb = 1'b1; reg_wr = 1'b1; reg_wdata = 8'h40;
    @(negedge clk); tx_dma_stb = 1'b0; reg_wr = 1'b0;
    check("R6 eob", int'(reg_rdata[4]), 1);
    check("R6 enable", int'(reg_rdata[6]), 0);
    wr(8'h00);

    // R10 load and strobe together
    load(1'b1, 2); wr(8'h80);
    @(negedge clk); rx_cnt_ld = 1'b1; cnt_ld_data = 8'd1; rx_dma_stb = 1'b1;
    @(negedge clk); rx_cnt_ld = 1'b0; rx_dma_stb = 1'b0;
    check("R10 count", int'(rx_cnt), 1);
    check("R10 no eob", int'(reg_rdata[5]), 0);
    wr(8'h00);

    // R9 event vs acknowledge
    wr(8'b0000_0100);
    pulse_evt(3'b100, 3'b100);
    check("R9 evt wins", int'(irq), 1);
    @(negedge clk);
    check("R9 held", int'(irq), 1);
    pulse_evt(3'b000, 3'b100);
    check("R9 acked", int'(irq), 0);

    // R8 exhaustive mask x source sweep
    for (int m = 0; m < 8; m++) begin
      for (int s = 0; s < 32; s++) begin
        logic [4:0] sv;
        logic [2:0] mv;
        int exp_irq;
        sv = 5'(s);
        mv = 3'(m);
        wr(8'h00);
        pulse_evt(3'b000, 3'b111);
        if (sv[4] || sv[3]) begin
          @(negedge clk); cnt_ld_data = 8'd1; rx_cnt_ld = sv[4]; tx_cnt_ld = sv[3];
          @(negedge clk); rx_cnt_ld = 1'b0; tx_cnt_ld = 1'b0;
          wr({sv[4], sv[3], 6'b000000});
          strobe({sv[4], sv[3]});
        end
        wr({2'b00, 2'b11, 1'b0, mv});
        pulse_evt(sv[2:0], 3'b000);
        exp_irq = ((sv[2:0] & mv) != 0 || (sv[4] && mv[1]) || (sv[3] && mv[0])) ? 1 : 0;
        check("R8 irq", int'(irq), exp_irq);
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule